// File: doc/BRIEF.md
# Partitioned Register Bank Arbiter

This block decides, in each cycle, which register-file bank serves which operand access. Collector units each present at most one pending source-operand read. The writeback path presents a group of destination registers that belong to one instruction. Every access carries a register number, a warp number and the number of the scheduler that issued the instruction. The block maps each access onto a bank. It grants at most one access per bank, and it tells writeback whether its whole group was taken this cycle.

Two mapping schemes can be chosen at run time. In shared mode every bank is open to every scheduler. In partitioned mode the banks are split into equal, contiguous groups, one group per scheduler, and an operand can only land in its own scheduler's group. A separate switch adds the warp number to the register number before the bank is chosen, so that warps spread across banks. No grant is held over from one cycle to the next; the only state is the round-robin position kept for each bank.

Top module: `regbank_arbiter`

## Requirements
- R1: With `part_en`=0 and `warp_mix_en`=0, an access to register r uses bank r mod NUM_BANKS.
- R2: With `part_en`=1, an access uses bank (base mod G) + s×G. Here G = NUM_BANKS/NUM_SCHED, s is the scheduler number, and base is the register number, with the warp number added when R3 applies. Every bank granted to an accepted writeback lies inside scheduler s's group.
- R3: With `warp_mix_en`=1, the base value is the register number plus the warp number, in both modes.
- R4: A writeback with `wb_valid`=1 is accepted (`wb_accept`=1, `wb_stall`=0) exactly when no two of its valid destinations map to the same bank. Otherwise `wb_stall`=1 and `wb_accept`=0. Destinations with their valid bit low are ignored. With `wb_valid`=0 both outputs are 0.
- R5: A refused writeback claims no bank: `bank_wr_gnt` is all zero in that cycle.
- R6: No bank is granted to a read and a write in the same cycle.
- R7: When an accepted write and a read target the same bank, the write wins. The read gets no grant and stays pending.
- R8: When several collector units request the same bank, the bank serves them in round-robin order. After unit k is served, the search in that bank's next grant starts at unit k+1, wrapping around.
- R9: `rd_gnt[c]` is set only when unit c requests. The number of units granted equals the number of banks set in `bank_rd_gnt`.
- R10: Grants last one cycle only. When no requests are present, all grant outputs are zero, whatever was granted before.
- R11: After reset, every bank's round-robin search starts at unit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the round-robin positions |
| part_en | input | 1 | 1: partitioned mapping, 0: shared mapping |
| warp_mix_en | input | 1 | 1: add the warp number to the register number |
| rd_req | input | NUM_CU | Read request per collector unit |
| rd_reg | input | NUM_CU×REG_W | Register number per unit, unit c at bits [c×REG_W +: REG_W] |
| rd_warp | input | NUM_CU×WARP_W | Warp number per unit |
| rd_sched | input | NUM_CU×SCHED_W | Scheduler number per unit |
| rd_gnt | output | NUM_CU | Read granted this cycle, per unit |
| wb_valid | input | 1 | Writeback group present |
| wb_dst_vld | input | NUM_DST | Valid bit per destination |
| wb_dst_reg | input | NUM_DST×REG_W | Destination register numbers |
| wb_warp | input | WARP_W | Warp number of the writeback |
| wb_sched | input | SCHED_W | Scheduler number of the writeback |
| wb_accept | output | 1 | Whole writeback group taken this cycle |
| wb_stall | output | 1 | Writeback refused this cycle |
| bank_rd_gnt | output | NUM_BANKS | Bank allocated to a read |
| bank_wr_gnt | output | NUM_BANKS | Bank allocated to a write |

## Verification
The assertions check the following on every cycle: a bank never carries both a read and a write; a refused writeback holds no bank; accept and stall never disagree; grants only follow requests, with as many units served as banks read; and accepted writes stay inside their scheduler's group in partitioned mode. The exact bank chosen for a given register, warp and scheduler under each mode, the rotation order among competing units, and the start position after reset can only be shown by the bench's directed scenarios, which compare the granted bank and unit against values worked out from the mapping rules.

// File: rtl/regbank_arb_pkg.sv
package regbank_arb_pkg;
   typedef enum logic [1:0] {
      BANK_IDLE  = 2'd0,
      BANK_READ  = 2'd1,
      BANK_WRITE = 2'd2
   } bank_use_e;
endpackage

// File: rtl/regbank_map.sv
module regbank_map #(
   parameter int NUM_BANKS = 8,
   parameter int NUM_SCHED = 4,
   parameter int REG_W     = 8,
   parameter int WARP_W    = 6,
   parameter int SCHED_W   = 2
) (
   input  logic [REG_W-1:0]     reg_i,
   input  logic [WARP_W-1:0]    warp_i,
   input  logic [SCHED_W-1:0]   sched_i,
   input  logic                 part_en,
   input  logic                 mix_en,
   output logic [NUM_BANKS-1:0] bank_oh
);
   localparam int GRP = NUM_BANKS / NUM_SCHED;

   logic [31:0] base_v;
   logic [31:0] shared_v;
   logic [31:0] part_v;
   logic [31:0] idx_v;

   always_comb begin
      base_v   = 32'(reg_i) + (mix_en ? 32'(warp_i) : 32'd0);
      shared_v = base_v % 32'(NUM_BANKS);
   end

   generate
      if (NUM_SCHED == 1) begin : g_single
         always_comb part_v = shared_v;
      end else begin : g_groups
         always_comb part_v = (base_v % 32'(GRP)) + 32'(sched_i) * 32'(GRP);
      end
   endgenerate

   always_comb begin
      idx_v = part_en ? part_v : shared_v;
      for (int b = 0; b < NUM_BANKS; b++) begin
         bank_oh[b] = (idx_v == 32'(b));
      end
   end
endmodule

// File: rtl/regbank_rr_pick.sv
module regbank_rr_pick #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         en,
   output logic [N-1:0] gnt,
   output logic         any
);
   logic [IW-1:0] ptr_q;
   logic [IW-1:0] win;

   always_comb begin
      win = '0;
      gnt = '0;
      any = |req;
      for (int k = N - 1; k >= 0; k--) begin
         int idx;
         idx = (int'(ptr_q) + k) % N;
         if (req[idx]) win = IW'(idx);
      end
      if (any) gnt[win] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (en && any) begin
         ptr_q <= (int'(win) == N - 1) ? '0 : win + IW'(1);
      end
   end
endmodule

// File: rtl/regbank_arbiter.sv
module regbank_arbiter
   import regbank_arb_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int NUM_SCHED = 4,
   parameter int NUM_CU    = 8,
   parameter int NUM_DST   = 2,
   parameter int REG_W     = 8,
   parameter int WARP_W    = 6,
   localparam int SCHED_W  = (NUM_SCHED > 1) ? $clog2(NUM_SCHED) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      part_en,
   input  logic                      warp_mix_en,
   input  logic [NUM_CU-1:0]         rd_req,
   input  logic [NUM_CU*REG_W-1:0]   rd_reg,
   input  logic [NUM_CU*WARP_W-1:0]  rd_warp,
   input  logic [NUM_CU*SCHED_W-1:0] rd_sched,
   output logic [NUM_CU-1:0]         rd_gnt,
   input  logic                      wb_valid,
   input  logic [NUM_DST-1:0]        wb_dst_vld,
   input  logic [NUM_DST*REG_W-1:0]  wb_dst_reg,
   input  logic [WARP_W-1:0]         wb_warp,
   input  logic [SCHED_W-1:0]        wb_sched,
   output logic                      wb_accept,
   output logic                      wb_stall,
   output logic [NUM_BANKS-1:0]      bank_rd_gnt,
   output logic [NUM_BANKS-1:0]      bank_wr_gnt
);
   generate
      if (NUM_BANKS % NUM_SCHED != 0) begin : g_bad_split
         $error("NUM_BANKS must be a multiple of NUM_SCHED");
      end
      if (NUM_CU < 1 || NUM_DST < 1) begin : g_bad_count
         $error("NUM_CU and NUM_DST must be at least 1");
      end
   endgenerate

   logic [NUM_BANKS-1:0] rd_oh   [NUM_CU];
   logic [NUM_BANKS-1:0] wr_oh   [NUM_DST];
   logic [NUM_BANKS-1:0] wr_sel  [NUM_DST];
   logic [NUM_CU-1:0]    bank_req[NUM_BANKS];
   logic [NUM_CU-1:0]    bank_pick[NUM_BANKS];
   logic [NUM_BANKS-1:0] bank_any;
   logic [NUM_BANKS-1:0] wr_claim;
   logic                 dst_clash;
   bank_use_e            bank_use[NUM_BANKS];

   // operand-to-bank mapping, one per collector unit
   generate
      for (genvar c = 0; c < NUM_CU; c++) begin : g_rd_map
         regbank_map #(
            .NUM_BANKS(NUM_BANKS), .NUM_SCHED(NUM_SCHED),
            .REG_W(REG_W), .WARP_W(WARP_W), .SCHED_W(SCHED_W)
         ) u_map (
            .reg_i  (rd_reg[c*REG_W +: REG_W]),
            .warp_i (rd_warp[c*WARP_W +: WARP_W]),
            .sched_i(rd_sched[c*SCHED_W +: SCHED_W]),
            .part_en(part_en),
            .mix_en (warp_mix_en),
            .bank_oh(rd_oh[c])
         );
      end
      for (genvar d = 0; d < NUM_DST; d++) begin : g_wr_map
         regbank_map #(
            .NUM_BANKS(NUM_BANKS), .NUM_SCHED(NUM_SCHED),
            .REG_W(REG_W), .WARP_W(WARP_W), .SCHED_W(SCHED_W)
         ) u_map (
            .reg_i  (wb_dst_reg[d*REG_W +: REG_W]),
            .warp_i (wb_warp),
            .sched_i(wb_sched),
            .part_en(part_en),
            .mix_en (warp_mix_en),
            .bank_oh(wr_oh[d])
         );
         assign wr_sel[d] = wb_dst_vld[d] ? wr_oh[d] : '0;
      end
   endgenerate

   // writeback: all-or-nothing, refused when two destinations share a bank
   always_comb begin
      dst_clash = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         int hits;
         hits = 0;
         for (int d = 0; d < NUM_DST; d++) begin
            if (wr_sel[d][b]) hits++;
         end
         if (hits > 1) dst_clash = 1'b1;
      end
      wb_accept = wb_valid && !dst_clash;
      wb_stall  = wb_valid && dst_clash;
      wr_claim  = '0;
      if (wb_accept) begin
         for (int d = 0; d < NUM_DST; d++) wr_claim = wr_claim | wr_sel[d];
      end
   end

   // per-bank read arbitration; a claimed write blocks the bank for reads
   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         for (genvar c = 0; c < NUM_CU; c++) begin : g_req
            assign bank_req[b][c] = rd_req[c] && rd_oh[c][b];
         end
         regbank_rr_pick #(.N(NUM_CU)) u_pick (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (bank_req[b]),
            .en   (!wr_claim[b]),
            .gnt  (bank_pick[b]),
            .any  (bank_any[b])
         );
         always_comb begin
            if (wr_claim[b])      bank_use[b] = BANK_WRITE;
            else if (bank_any[b]) bank_use[b] = BANK_READ;
            else                  bank_use[b] = BANK_IDLE;
         end
         assign bank_rd_gnt[b] = (bank_use[b] == BANK_READ);
         assign bank_wr_gnt[b] = (bank_use[b] == BANK_WRITE);
      end
   endgenerate

   always_comb begin
      rd_gnt = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bank_use[b] == BANK_READ) rd_gnt = rd_gnt | bank_pick[b];
      end
   end
endmodule

// File: rtl/regbank_arbiter_chk.sv
module regbank_arbiter_chk #(
   parameter int NUM_BANKS = 8,
   parameter int NUM_SCHED = 4,
   parameter int NUM_CU    = 8,
   parameter int SCHED_W   = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 part_en,
   input logic                 wb_valid,
   input logic                 wb_accept,
   input logic                 wb_stall,
   input logic [SCHED_W-1:0]   wb_sched,
   input logic [NUM_CU-1:0]    rd_req,
   input logic [NUM_CU-1:0]    rd_gnt,
   input logic [NUM_BANKS-1:0] bank_rd_gnt,
   input logic [NUM_BANKS-1:0] bank_wr_gnt
);
   localparam int GRP = NUM_BANKS / NUM_SCHED;
   logic [NUM_BANKS-1:0] own_grp;

   always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) own_grp[b] = ((b / GRP) == int'(wb_sched));
   end

   // R6
   one_use_per_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_rd_gnt & bank_wr_gnt) == '0);
   // R5
   refused_wb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_stall |-> (bank_wr_gnt == '0));
   // R4
   wb_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_accept != wb_stall));
   // R4
   no_wb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_valid |-> (!wb_accept && !wb_stall));
   // R9
   gnt_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_gnt & ~rd_req) == '0);
   // R9
   gnt_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rd_gnt) == $countones(bank_rd_gnt));
   // R2
   wr_in_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (part_en && wb_accept) |-> ((bank_wr_gnt & ~own_grp) == '0));
endmodule

bind regbank_arbiter regbank_arbiter_chk #(
   .NUM_BANKS(NUM_BANKS), .NUM_SCHED(NUM_SCHED), .NUM_CU(NUM_CU), .SCHED_W(SCHED_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .part_en(part_en), .wb_valid(wb_valid),
   .wb_accept(wb_accept), .wb_stall(wb_stall), .wb_sched(wb_sched),
   .rd_req(rd_req), .rd_gnt(rd_gnt),
   .bank_rd_gnt(bank_rd_gnt), .bank_wr_gnt(bank_wr_gnt)
);

// File: tb/regbank_arbiter_tb_top.sv
module regbank_arbiter_tb_top;
   localparam int NB = 8, NS = 4, NC = 8, ND = 2, RW = 8, WW = 6, SW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic part_en = 1'b0, warp_mix_en = 1'b0;
   logic [NC-1:0]    rd_req = '0;
   logic [NC*RW-1:0] rd_reg = '0;
   logic [NC*WW-1:0] rd_warp = '0;
   logic [NC*SW-1:0] rd_sched = '0;
   logic [NC-1:0]    rd_gnt;
   logic             wb_valid = 1'b0;
   logic [ND-1:0]    wb_dst_vld = '0;
   logic [ND*RW-1:0] wb_dst_reg = '0;
   logic [WW-1:0]    wb_warp = '0;
   logic [SW-1:0]    wb_sched = '0;
   logic             wb_accept, wb_stall;
   logic [NB-1:0]    bank_rd_gnt, bank_wr_gnt;

   int n_chk = 0, n_bad = 0;

   // 50 MHz: 20-unit period in ns
   always #10 clk = ~clk;

   regbank_arbiter #(
      .NUM_BANKS(NB), .NUM_SCHED(NS), .NUM_CU(NC), .NUM_DST(ND), .REG_W(RW), .WARP_W(WW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .part_en(part_en), .warp_mix_en(warp_mix_en),
      .rd_req(rd_req), .rd_reg(rd_reg), .rd_warp(rd_warp), .rd_sched(rd_sched),
      .rd_gnt(rd_gnt), .wb_valid(wb_valid), .wb_dst_vld(wb_dst_vld),
      .wb_dst_reg(wb_dst_reg), .wb_warp(wb_warp), .wb_sched(wb_sched),
      .wb_accept(wb_accept), .wb_stall(wb_stall),
      .bank_rd_gnt(bank_rd_gnt), .bank_wr_gnt(bank_wr_gnt)
   );

   function automatic int exp_bank(int r, int w, int s, bit part, bit mix);
      int base;
      base = r + (mix ? w : 0);
      if (part) return (base % (NB / NS)) + s * (NB / NS);
      return base % NB;
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic clear_all();
      rd_req = '0; rd_reg = '0; rd_warp = '0; rd_sched = '0;
      wb_valid = 1'b0; wb_dst_vld = '0; wb_dst_reg = '0; wb_warp = '0; wb_sched = '0;
   endtask

   task automatic set_rd(int c, int r, int w, int s);
      rd_req[c] = 1'b1;
      rd_reg[c*RW +: RW] = RW'(r);
      rd_warp[c*WW +: WW] = WW'(w);
      rd_sched[c*SW +: SW] = SW'(s);
   endtask

   task automatic set_wb(bit v0, int r0, bit v1, int r1, int w, int s);
      wb_valid = 1'b1;
      wb_dst_vld = {v1, v0};
      wb_dst_reg = {RW'(r1), RW'(r0)};
      wb_warp = WW'(w);
      wb_sched = SW'(s);
   endtask

   // drive at the falling edge, sample halfway to the next rising edge
   task automatic step();
      @(negedge clk);
   endtask

   task automatic settle();
      #5;
   endtask

   task automatic t_reset();
      step(); clear_all(); settle();
      check("R10", "idle rd_gnt", 32'(rd_gnt), 0);
      check("R10", "idle bank_rd_gnt", 32'(bank_rd_gnt), 0);
      check("R10", "idle bank_wr_gnt", 32'(bank_wr_gnt), 0);
      check("R4", "idle accept/stall", {30'd0, wb_accept, wb_stall}, 0);
   endtask

   task automatic t_shared();
      step(); clear_all(); part_en = 0; warp_mix_en = 0;
      set_rd(0, 13, 4, 3); settle();
      check("R1", "shared bank reg13", 32'(bank_rd_gnt), 32'(1) << exp_bank(13, 4, 3, 0, 0));
      check("R1", "shared rd_gnt", 32'(rd_gnt), 32'h1);
   endtask

   task automatic t_mix();
      step(); clear_all(); part_en = 0; warp_mix_en = 1;
      set_rd(2, 13, 4, 0); settle();
      check("R3", "shared+mix bank", 32'(bank_rd_gnt), 32'(1) << exp_bank(13, 4, 0, 0, 1));
      step(); clear_all(); part_en = 1; warp_mix_en = 1;
      set_rd(4, 3, 2, 1); settle();
      check("R3", "part+mix bank", 32'(bank_rd_gnt), 32'(1) << exp_bank(3, 2, 1, 1, 1));
   endtask

   task automatic t_part();
      step(); clear_all(); part_en = 1; warp_mix_en = 0;
      set_rd(0, 13, 0, 2); set_rd(1, 12, 0, 3); settle();
      check("R2", "part banks", 32'(bank_rd_gnt),
            (32'(1) << exp_bank(13, 0, 2, 1, 0)) | (32'(1) << exp_bank(12, 0, 3, 1, 0)));
      check("R2", "part rd_gnt", 32'(rd_gnt), 32'h3);
      step(); clear_all(); part_en = 1; warp_mix_en = 0;
      set_wb(1, 0, 1, 2, 0, 0); settle();
      check("R2", "part wb clash stall", {31'd0, wb_stall}, 1);
      check("R5", "part clash no write", 32'(bank_wr_gnt), 0);
      step(); clear_all(); part_en = 1;
      set_wb(1, 4, 1, 7, 0, 1); settle();
      check("R2", "part wb accept", {31'd0, wb_accept}, 1);
      check("R2", "part wb banks", 32'(bank_wr_gnt),
            (32'(1) << exp_bank(4, 0, 1, 1, 0)) | (32'(1) << exp_bank(7, 0, 1, 1, 0)));
   endtask

   task automatic t_rr();
      // bank 2 not used before: its search starts at unit 0 (R11)
      step(); clear_all(); part_en = 0; warp_mix_en = 0;
      set_rd(0, 2, 0, 0); set_rd(3, 10, 0, 0); set_rd(5, 18, 0, 0); settle();
      check("R11", "first winner", 32'(rd_gnt), 32'h01);
      step(); settle();
      check("R8", "second winner", 32'(rd_gnt), 32'h08);
      step(); settle();
      check("R8", "third winner", 32'(rd_gnt), 32'h20);
      step(); settle();
      check("R8", "wrap winner", 32'(rd_gnt), 32'h01);
      check("R9", "single bank read", 32'(bank_rd_gnt), 32'h04);
   endtask

   task automatic t_write_first();
      step(); clear_all(); part_en = 0; warp_mix_en = 0;
      set_wb(1, 2, 1, 7, 0, 0); set_rd(0, 10, 0, 0); set_rd(1, 4, 0, 0); settle();
      check("R4", "distinct dst accept", {30'd0, wb_accept, wb_stall}, 32'h2);
      check("R7", "write banks", 32'(bank_wr_gnt), 32'h84);
      check("R7", "read loses bank2", 32'(rd_gnt), 32'h02);
      check("R6", "read banks", 32'(bank_rd_gnt), 32'h10);
      step(); wb_valid = 1'b0; settle();
      check("R7", "read pending then served", 32'(rd_gnt), 32'h03);
   endtask

   task automatic t_conflict();
      step(); clear_all(); part_en = 0; warp_mix_en = 0;
      set_wb(1, 3, 1, 11, 0, 0); set_rd(0, 3, 0, 0); settle();
      check("R4", "same-bank dst stall", {30'd0, wb_accept, wb_stall}, 32'h1);
      check("R5", "stalled no write", 32'(bank_wr_gnt), 0);
      check("R5", "read takes free bank", 32'(bank_rd_gnt), 32'h08);
      step(); clear_all();
      set_wb(0, 3, 1, 11, 0, 0); settle();
      check("R4", "invalid dst ignored", {30'd0, wb_accept, wb_stall}, 32'h2);
      check("R4", "only valid dst written", 32'(bank_wr_gnt), 32'h08);
   endtask

   task automatic t_clear();
      step(); clear_all(); settle();
      check("R10", "cleared rd", 32'(bank_rd_gnt | bank_wr_gnt), 0);
      check("R10", "cleared units", 32'(rd_gnt), 0);
   endtask

   initial begin
      #(20 * 100000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_shared();
      t_mix();
      t_part();
      t_rr();
      t_write_first();
      t_conflict();
      t_clear();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule